// File: doc/BRIEF.md
# Threshold Programming Sequence Detector

This block watches a four-wire serial command link in clock-phase-0 form and picks out one special two-frame command. Each frame is a chip-select low window carrying exactly 24 data bits, most significant first, captured on rising serial clock edges. The first frame arms the detector. The second frame, which must follow within a bounded gap, asks for either a raise-threshold or a clear-threshold action. The downstream trim logic receives a one-cycle strobe for the action that was asked for. After the strobe the block holds a busy flag through a self-timed write interval and then a recovery interval. During that time any further command traffic is ignored.

The sequence is honoured only while a program-enable level is high. If that level drops before the action strobe, the sequence is abandoned. All four link inputs and the enable are asynchronous to the block. They pass through a synchronizer and are sampled on the system clock, so the serial clock must run well below the system clock. The link has no back-pressure: the serial master owns the pace, and the block has no ready signal. Internally the frame receiver hands each finished frame to the sequencer as a single valid pulse. The sequencer always takes it in that same cycle.

Top module: `trip_prog_seq_det`

## Requirements
- R1: After reset, `set_stb`, `clr_stb` and `busy` are all low.
- R2: With `prog_en` high, the arm frame 0x030001 followed by the frame 0x020001 gives exactly one `set_stb` pulse and no `clr_stb`. Each frame is 24 bits, MSB first.
- R3: With `prog_en` high, the arm frame 0x030001 followed by the frame 0x020003 gives exactly one `clr_stb` pulse and no `set_stb`.
- R4: Each strobe lasts exactly one cycle and is high in the same cycle that `busy` rises. The two strobes are never high together.
- R5: `busy` stays high for exactly WRITE_CYCLES + RECOVER_CYCLES consecutive cycles after a strobe.
- R6: If `prog_en` is low when either frame completes, or at any cycle between the two frames, no strobe is produced.
- R7: A frame with any bit count other than 24 (counted as rising `sck` edges while `cs_n` is low) is rejected and no strobe follows.
- R8: A first frame other than 0x030001, or a second frame other than 0x020001 or 0x020003, gives no strobe.
- R9: The second frame is rejected if `cs_n` stays high for fewer than GAP_MIN system cycles between the two frames.
- R10: The second frame is rejected if `cs_n` stays high for more than GAP_MAX system cycles between the two frames.
- R11: A complete, valid sequence that arrives while `busy` is high produces no strobe and does not lengthen `busy`.
- R12: After any rejected sequence the detector is idle again, and the next valid sequence is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low, asynchronous |
| sck | input | 1 | Serial clock, data captured on its rising edge, asynchronous |
| mosi | input | 1 | Serial data toward the block, asynchronous |
| prog_en | input | 1 | Program-enable qualifier level, asynchronous |
| set_stb | output | 1 | One-cycle request to raise or set the threshold |
| clr_stb | output | 1 | One-cycle request to clear the threshold |
| busy | output | 1 | High through the write interval and the recovery interval |

## Verification
The hardest state to reach from the ports is a complete, valid sequence that lands entirely inside the busy window. To get there, the bench shortens the gap limits and makes the write plus recovery interval longer than one full two-frame sequence. It then launches the second sequence at once after the first strobe.

The gap limits are swept cycle by cycle on both sides of GAP_MIN and GAP_MAX. Frame lengths are swept from 20 to 28 bits, and every single-bit corruption of the arm word is tried. Each expected result is worked out from the bit count, the gap and the word values.

// File: rtl/tps_pkg.sv
package tps_pkg;

  localparam int unsigned FRAME_BITS = 24;

  // Frame words; the trailing byte of the second frame selects the action.
  localparam logic [FRAME_BITS-1:0] ARM_WORD = 24'h030001;
  localparam logic [FRAME_BITS-1:0] SET_WORD = 24'h020001;
  localparam logic [FRAME_BITS-1:0] CLR_WORD = 24'h020003;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_GAP     = 3'd1,
    ST_FRAME2  = 3'd2,
    ST_WRITE   = 3'd3,
    ST_RECOVER = 3'd4
  } seq_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/tps_sync.sv
module tps_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/tps_frame_rx.sv
module tps_frame_rx #(
  parameter int unsigned BITS = 24,
  localparam int unsigned MAXC = BITS + 1,
  localparam int unsigned CW = $clog2(MAXC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_s,
  input  logic            sck_s,
  input  logic            sdi_s,
  output logic            frame_vld,
  output logic            frame_start,
  output logic            frame_len_ok,
  output logic [BITS-1:0] frame_word
);

  logic          cs_q;
  logic          sck_q;
  logic [CW-1:0] cnt;
  logic [BITS-1:0] shreg;
  logic          sck_rise;
  logic          cs_fall;

  assign sck_rise = sck_s & ~sck_q & ~cs_s;
  assign cs_fall  = ~cs_s & cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  // Bit counter saturates one past a legal frame so over-length stays wrong.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
    end else if (sck_rise && cnt != CW'(MAXC)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else if (sck_rise) shreg <= {shreg[BITS-2:0], sdi_s};
  end

  assign frame_vld    = cs_s & ~cs_q;
  assign frame_start  = cs_fall;
  assign frame_len_ok = (cnt == CW'(BITS));
  assign frame_word   = shreg;

  // R7: the counter never wraps back into the legal length
  a_r7_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(MAXC) && !cs_fall) |=> (cnt == CW'(MAXC)));

  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAXC));

endmodule

// File: rtl/tps_seq_fsm.sv
module tps_seq_fsm
  import tps_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 10000,
  parameter int unsigned RECOVER_CYCLES = 10000,
  parameter int unsigned GAP_MIN = 2,
  parameter int unsigned GAP_MAX = 100000,
  localparam int unsigned TMAX = max3(WRITE_CYCLES, RECOVER_CYCLES, GAP_MAX),
  localparam int unsigned TW = $clog2(TMAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_vld,
  input  logic                  frame_start,
  input  logic                  frame_len_ok,
  input  logic [FRAME_BITS-1:0] frame_word,
  input  logic                  prog_en_s,
  output logic                  set_o,
  output logic                  clr_o,
  output logic                  busy_o
);

  localparam logic [TW-1:0] WR_LOAD  = TW'(WRITE_CYCLES - 1);
  localparam logic [TW-1:0] REC_LOAD = TW'(RECOVER_CYCLES - 1);
  localparam logic [TW-1:0] GMIN_M1  = TW'(GAP_MIN - 1);
  localparam logic [TW-1:0] GMAX_M1  = TW'(GAP_MAX - 1);

  seq_state_e    state, state_n;
  logic [TW-1:0] tmr, tmr_n;
  logic          set_n, clr_n;
  logic          good_frame;

  assign good_frame = frame_vld & frame_len_ok & prog_en_s;

  always_comb begin
    state_n = state;
    tmr_n   = tmr;
    set_n   = 1'b0;
    clr_n   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (good_frame && frame_word == ARM_WORD) begin
          state_n = ST_GAP;
          tmr_n   = '0;
        end
      end
      ST_GAP: begin
        if (!prog_en_s) begin
          state_n = ST_IDLE;
        end else if (frame_start) begin
          state_n = (tmr >= GMIN_M1) ? ST_FRAME2 : ST_IDLE;
        end else if (tmr == GMAX_M1) begin
          state_n = ST_IDLE;
        end else begin
          tmr_n = tmr + 1'b1;
        end
      end
      ST_FRAME2: begin
        if (!prog_en_s) begin
          state_n = ST_IDLE;
        end else if (frame_vld) begin
          if (good_frame && frame_word == SET_WORD) begin
            state_n = ST_WRITE;
            tmr_n   = WR_LOAD;
            set_n   = 1'b1;
          end else if (good_frame && frame_word == CLR_WORD) begin
            state_n = ST_WRITE;
            tmr_n   = WR_LOAD;
            clr_n   = 1'b1;
          end else begin
            state_n = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        if (tmr == '0) begin
          state_n = ST_RECOVER;
          tmr_n   = REC_LOAD;
        end else begin
          tmr_n = tmr - 1'b1;
        end
      end
      ST_RECOVER: begin
        if (tmr == '0) state_n = ST_IDLE;
        else tmr_n = tmr - 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tmr    <= '0;
      set_o  <= 1'b0;
      clr_o  <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      state  <= state_n;
      tmr    <= tmr_n;
      set_o  <= set_n;
      clr_o  <= clr_n;
      busy_o <= (state_n == ST_WRITE) || (state_n == ST_RECOVER);
    end
  end

  // R4: strobes are single cycle, exclusive, and open the busy window
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (set_o || clr_o) |=> !(set_o || clr_o));

  a_r4_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (set_o || clr_o) |-> $rose(busy_o));

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_o && clr_o));

  // R5: write interval is not cut short
  a_r5_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE && tmr != '0) |=> (state == ST_WRITE && busy_o));

  // R6: losing the enable mid-sequence abandons it
  a_r6_enable_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_en_s && (state == ST_GAP || state == ST_FRAME2)) |=> (state == ST_IDLE));

  // R11: no strobe while an earlier action is still running
  a_r11_busy_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> !(set_o || clr_o));

endmodule

// File: rtl/trip_prog_seq_det.sv
module trip_prog_seq_det
  import tps_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WRITE_CYCLES = 10000,
  parameter int unsigned RECOVER_CYCLES = 10000,
  parameter int unsigned GAP_MIN = 2,
  parameter int unsigned GAP_MAX = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic prog_en,
  output logic set_stb,
  output logic clr_stb,
  output logic busy
);

  localparam int unsigned NSIG = 4;
  localparam logic [NSIG-1:0] SYNC_RST = 4'b1000;

  logic [NSIG-1:0] raw_v, syn_v;
  logic            frame_vld, frame_start, frame_len_ok;
  logic [FRAME_BITS-1:0] frame_word;

  assign raw_v = {cs_n, sck, mosi, prog_en};

  tps_sync #(
    .WIDTH  (NSIG),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_v),
    .q    (syn_v)
  );

  tps_frame_rx #(
    .BITS(FRAME_BITS)
  ) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (syn_v[3]),
    .sck_s       (syn_v[2]),
    .sdi_s       (syn_v[1]),
    .frame_vld   (frame_vld),
    .frame_start (frame_start),
    .frame_len_ok(frame_len_ok),
    .frame_word  (frame_word)
  );

  tps_seq_fsm #(
    .WRITE_CYCLES  (WRITE_CYCLES),
    .RECOVER_CYCLES(RECOVER_CYCLES),
    .GAP_MIN       (GAP_MIN),
    .GAP_MAX       (GAP_MAX)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_vld   (frame_vld),
    .frame_start (frame_start),
    .frame_len_ok(frame_len_ok),
    .frame_word  (frame_word),
    .prog_en_s   (syn_v[0]),
    .set_o       (set_stb),
    .clr_o       (clr_stb),
    .busy_o      (busy)
  );

  // R1: quiet outputs out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(set_stb || clr_stb || busy));

endmodule

// File: tb/trip_prog_seq_det_tb_top.sv
`timescale 1ns/1ps
module trip_prog_seq_det_tb_top;

  localparam int WR   = 300;
  localparam int REC  = 200;
  localparam int GMIN = 4;
  localparam int GMAX = 40;
  localparam int QUIET = WR + REC + GMAX + 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, prog_en = 1'b0;
  logic set_stb, clr_stb, busy;

  int n_tests = 0;
  int n_fail = 0;
  int set_cnt = 0, clr_cnt = 0, busy_runs = 0, run = 0, last_len = 0, bad4 = 0;
  logic prev_busy = 1'b0, prev_stb = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  trip_prog_seq_det #(
    .SYNC_STAGES(2), .WRITE_CYCLES(WR), .RECOVER_CYCLES(REC),
    .GAP_MIN(GMIN), .GAP_MAX(GMAX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .prog_en(prog_en), .set_stb(set_stb), .clr_stb(clr_stb), .busy(busy)
  );

  // Output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (set_stb) set_cnt++;
      if (clr_stb) clr_cnt++;
      // R4: strobe must coincide with busy rising and last one cycle
      if ((set_stb || clr_stb) && !(busy && !prev_busy)) bad4++;
      if ((set_stb || clr_stb) && prev_stb) bad4++;
      if (set_stb && clr_stb) bad4++;
      if (busy) run++;
      else if (run != 0) begin
        last_len = run;
        run = 0;
        busy_runs++;
      end
      prev_busy = busy;
      prev_stb  = set_stb || clr_stb;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Frame: nbits bits of word, MSB first; leaves cs_n high at a negedge
  task automatic send_frame(input logic [31:0] word, input int nbits);
    cs_n = 1'b0;
    wait_n(3);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = word[i];
      wait_n(2);
      sck = 1'b1;
      wait_n(3);
      sck = 1'b0;
      wait_n(1);
    end
    wait_n(2);
    cs_n = 1'b1;
  endtask

  task automatic seq(input logic [31:0] w1, input int n1, input int gap,
                     input logic [31:0] w2, input int n2);
    send_frame(w1, n1);
    wait_n(gap);
    send_frame(w2, n2);
  endtask

  task automatic expect_result(input string req, input int e_set, input int e_clr,
                               input int s0, input int c0);
    wait_n(QUIET);
    chk({req, " set strobes"}, set_cnt - s0, e_set);
    chk({req, " clear strobes"}, clr_cnt - c0, e_clr);
  endtask

  initial begin
    int s0, c0, r0;
    wait_n(5);
    chk("R1 set_stb in reset", int'(set_stb), 0);
    rst_n = 1'b1;
    wait_n(5);
    chk("R1 set_stb after reset", int'(set_stb), 0);
    chk("R1 clr_stb after reset", int'(clr_stb), 0);
    chk("R1 busy after reset", int'(busy), 0);
    prog_en = 1'b1;
    wait_n(5);

    // R2, R5: set sequence
    s0 = set_cnt; c0 = clr_cnt; r0 = busy_runs;
    seq(32'h030001, 24, 10, 32'h020001, 24);
    expect_result("R2", 1, 0, s0, c0);
    chk("R5 busy length", last_len, WR + REC);
    chk("R5 busy runs", busy_runs - r0, 1);

    // R3: clear sequence
    s0 = set_cnt; c0 = clr_cnt;
    seq(32'h030001, 24, 10, 32'h020003, 24);
    expect_result("R3", 0, 1, s0, c0);
    chk("R5 busy length after clear", last_len, WR + REC);

    // R8: trailing byte sweep of the second frame
    for (int b = 0; b < 8; b++) begin
      s0 = set_cnt; c0 = clr_cnt;
      seq(32'h030001, 24, 10, 32'h020000 | b, 24);
      expect_result("R8 trailing byte", (b == 1) ? 1 : 0, (b == 3) ? 1 : 0, s0, c0);
    end

    // R8: every single-bit corruption of the arm word
    for (int k = 0; k < 24; k++) begin
      s0 = set_cnt; c0 = clr_cnt;
      seq(32'h030001 ^ (32'h1 << k), 24, 10, 32'h020001, 24);
      expect_result("R8 arm corrupt", 0, 0, s0, c0);
    end

    // R8: second frame alone, and set word as first frame
    s0 = set_cnt; c0 = clr_cnt;
    seq(32'h020001, 24, 10, 32'h020001, 24);
    expect_result("R8 no arm", 0, 0, s0, c0);

    // R7: bit count sweep on each frame
    for (int n = 20; n <= 28; n++) begin
      s0 = set_cnt; c0 = clr_cnt;
      seq(32'h030001, n, 10, 32'h020001, 24);
      expect_result("R7 first frame length", (n == 24) ? 1 : 0, 0, s0, c0);
      s0 = set_cnt; c0 = clr_cnt;
      seq(32'h030001, 24, 10, 32'h020003, n);
      expect_result("R7 second frame length", 0, (n == 24) ? 1 : 0, s0, c0);
    end

    // R9: short gap sweep
    for (int g = 1; g <= GMIN + 2; g++) begin
      s0 = set_cnt; c0 = clr_cnt;
      seq(32'h030001, 24, g, 32'h020001, 24);
      expect_result("R9 gap", (g >= GMIN) ? 1 : 0, 0, s0, c0);
    end

    // R10: long gap sweep
    for (int g = GMAX - 3; g <= GMAX + 3; g++) begin
      s0 = set_cnt; c0 = clr_cnt;
      seq(32'h030001, 24, g, 32'h020003, 24);
      expect_result("R10 gap", 0, (g <= GMAX) ? 1 : 0, s0, c0);
    end

    // R6: enable low for the whole sequence
    prog_en = 1'b0;
    wait_n(5);
    s0 = set_cnt; c0 = clr_cnt;
    seq(32'h030001, 24, 10, 32'h020001, 24);
    expect_result("R6 enable low", 0, 0, s0, c0);
    prog_en = 1'b1;
    wait_n(5);

    // R6: enable dropped briefly in the gap
    s0 = set_cnt; c0 = clr_cnt;
    send_frame(32'h030001, 24);
    wait_n(3);
    prog_en = 1'b0;
    wait_n(4);
    prog_en = 1'b1;
    wait_n(5);
    send_frame(32'h020001, 24);
    expect_result("R6 enable pulse low in gap", 0, 0, s0, c0);

    // R6: enable low only while the second frame completes
    s0 = set_cnt; c0 = clr_cnt;
    send_frame(32'h030001, 24);
    wait_n(10);
    cs_n = 1'b0;
    wait_n(3);
    for (int i = 23; i >= 0; i--) begin
      mosi = (i == 0) ? 1'b1 : ((i == 17) ? 1'b1 : 1'b0);
      wait_n(2); sck = 1'b1; wait_n(3); sck = 1'b0; wait_n(1);
    end
    prog_en = 1'b0;
    wait_n(6);
    cs_n = 1'b1;
    wait_n(6);
    prog_en = 1'b1;
    expect_result("R6 enable low at frame end", 0, 0, s0, c0);

    // R12: a good sequence after rejections is accepted
    s0 = set_cnt; c0 = clr_cnt;
    seq(32'h030001, 24, 10, 32'h020001, 24);
    expect_result("R12 recovery to idle", 1, 0, s0, c0);

    // R11: valid sequence launched inside the busy window
    s0 = set_cnt; c0 = clr_cnt; r0 = busy_runs;
    seq(32'h030001, 24, 10, 32'h020001, 24);
    wait_n(4);
    chk("R11 busy at second launch", int'(busy), 1);
    seq(32'h030001, 24, 10, 32'h020003, 24);
    chk("R11 still busy after second sequence", int'(busy), 1);
    expect_result("R11 ignored while busy", 1, 0, s0, c0);
    chk("R11 busy runs", busy_runs - r0, 1);
    chk("R11 busy length", last_len, WR + REC);

    chk("R4 strobe timing violations", bad4, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 195000; i++) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule